// File: doc/BRIEF.md
# Interval Timer with Immediate Compare Reload

This block is a 16-bit up-counting interval timer. While running, it advances its count once for every cycle in which the count-clock enable is high. When the count equals the compare value, the count returns to zero on that same tick. One clock later the block raises a single-cycle interrupt pulse and inverts its timer output pin. With a compare value D, interrupts are therefore spaced D + 1 ticks apart.

The compare value comes from a plain write strobe with a data word. A write is copied into the active compare buffer on the clock edge where the strobe is sampled. The block does not wait for the end of the current period. If the new value is at or above the current count, the current period simply ends at the new value. If the new value is below the count, the counter runs on to FFFFH, wraps to 0000H and only then reaches the new value, so that one period lasts 10000H + D + 1 ticks. Software that wants to lower the compare value without this long period clears the run control first, writes the value, and then sets run again.

When the run control is low, the count is held at zero, interrupts are suppressed and the output pin takes a software-chosen starting level. A synchronous active-high reset clears the count, drives the pin low and sets the compare buffer to FFFFH. The block has no data stream, so every pin is a plain level or strobe.

Top module: `ivl_timer`

## Requirements
- R1: After reset, irq and tout are 0 and the compare buffer holds FFFFH. If no write follows, the first irq comes 65536 ticks after run is set.
- R2: The count advances only on clock edges where both run and tick are high. On other edges it holds.
- R3: Each match produces an irq pulse exactly one clock wide, one clock after the matching tick. In that same clock, tout inverts.
- R4: With compare value D, there are exactly D + 1 ticks between successive irq pulses, and between setting run and the first irq. The count is 0 in the cycle irq is high.
- R5: A compare write is loaded on the edge where cmp_wr is high. If the new value is at or above the count, the current period ends at the new value.
- R6: If a write sets the compare value below the current count, the count passes FFFFH, wraps to 0000H and matches the new value D. That period lasts 65536 + D + 1 ticks. The next period lasts D + 1 ticks.
- R7: A write on the same edge as a match does not change that match. The new value governs the following period.
- R8: While run is low, the count is held at 0, irq stays 0, and tout follows idle_level one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-clock enable; one tick per high cycle |
| run | input | 1 | Count enable; low stops and clears the timer |
| idle_level | input | 1 | Starting level of tout while stopped |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 16 | Compare value to load |
| irq | output | 1 | Single-cycle compare-match interrupt |
| tout | output | 1 | Timer output, inverted on each match |

## Verification
Several behaviours are checked by the assertions on every cycle:
- the reset state;
- count holding when there is no tick, and stepping by one with natural wrap otherwise;
- tout inverting exactly when irq is high;
- the count being zero whenever irq is high;
- compare writes landing on the next edge;
- the stopped state.

Other behaviours involve whole periods, so only the bench scenarios can show them:
- the interval lengths of D + 1 ticks;
- the 65536-tick first period after reset;
- the stretched 65536 + D + 1 period after a lowering write;
- the same-edge write that leaves the current match unchanged.

// File: rtl/ivl_timer_pkg.sv
`timescale 1ns/1ps
package ivl_timer_pkg;
  // Default counter and compare width.
  localparam int unsigned IVL_DEF_W = 16;
endpackage

// File: rtl/ivl_cmp_hold.sv
`timescale 1ns/1ps
// Active compare buffer: loads on every write, no period-boundary wait.
module ivl_cmp_hold #(
  parameter int unsigned W = ivl_timer_pkg::IVL_DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmp
);
  logic [W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (rst)     cmp_q <= '1;
    else if (wr) cmp_q <= wdata;
  end

  assign cmp = cmp_q;
endmodule

// File: rtl/ivl_counter.sv
`timescale 1ns/1ps
// Up counter with match detection; clears on the matching tick.
module ivl_counter #(
  parameter int unsigned W = ivl_timer_pkg::IVL_DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  // The match uses the buffer value held before this edge.
  assign hit = run && tick && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= hit ? '0 : cnt_q + W'(1);
  end

  assign count = cnt_q;
endmodule

// File: rtl/ivl_pin_out.sv
`timescale 1ns/1ps
// Registered interrupt pulse and toggling output pin.
module ivl_pin_out (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic idle_level,
  input  logic hit,
  output logic irq,
  output logic tout
);
  logic irq_q;
  logic tout_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit;
  end

  always_ff @(posedge clk) begin
    if (rst)       tout_q <= 1'b0;
    else if (!run) tout_q <= idle_level;
    else if (hit)  tout_q <= ~tout_q;
  end

  assign irq  = irq_q;
  assign tout = tout_q;
endmodule

// File: rtl/ivl_timer.sv
`timescale 1ns/1ps
module ivl_timer #(
  parameter int unsigned W = ivl_timer_pkg::IVL_DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         idle_level,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic         irq,
  output logic         tout
);
  logic [W-1:0] cmp_q;
  logic [W-1:0] count_q;
  logic         hit;

  ivl_cmp_hold #(.W(W)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .wr    (cmp_wr),
    .wdata (cmp_wdata),
    .cmp   (cmp_q)
  );

  ivl_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .tick  (tick),
    .limit (cmp_q),
    .count (count_q),
    .hit   (hit)
  );

  ivl_pin_out u_pin (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .idle_level (idle_level),
    .hit        (hit),
    .irq        (irq),
    .tout       (tout)
  );
endmodule

// File: rtl/ivl_timer_chk.sv
`timescale 1ns/1ps
module ivl_timer_chk #(
  parameter int unsigned W = ivl_timer_pkg::IVL_DEF_W
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         run,
  input logic         idle_level,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_wdata,
  input logic         irq,
  input logic         tout,
  input logic [W-1:0] cmp,
  input logic [W-1:0] count
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !tout && cmp == '1 && count == '0));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run) && !$past(tick)) |-> count == $past(count));

  assert_toggle_on_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run)) |-> ((tout != $past(tout)) == irq));

  assert_clear_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> count == '0);

  assert_load_at_once_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmp_wr)) |-> cmp == $past(cmp_wdata));

  assert_step_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run) && $past(tick) && !irq) |-> count == W'($past(count) + W'(1)));

  assert_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run)) |-> (!irq && tout == $past(idle_level) && count == '0));
endmodule

bind ivl_timer ivl_timer_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .run        (run),
  .idle_level (idle_level),
  .cmp_wr     (cmp_wr),
  .cmp_wdata  (cmp_wdata),
  .irq        (irq),
  .tout       (tout),
  .cmp        (cmp_q),
  .count      (count_q)
);

// File: tb/ivl_timer_bench.sv
`timescale 1ns/1ps
module ivl_timer_bench;
  localparam int W = 16;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         run = 1'b0;
  logic         idle_level = 1'b0;
  logic         cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         irq;
  logic         tout;

  int checks = 0;
  int errors = 0;
  int ticks = 0;
  int tick_pct = 100;
  int pulse_err = 0;
  int tout_err = 0;
  int periods[$];
  bit exp_tout = 1'b0;
  bit prev_irq = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ivl_timer #(.W(W)) u_ivl_timer (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .idle_level(idle_level),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .irq(irq), .tout(tout)
  );

  function automatic int normal_period(int d);
    return d + 1;
  endfunction

  function automatic int wrap_period(int d);
    return SPAN + d + 1;
  endfunction

  function automatic int get(int i);
    if (i < periods.size()) return periods[i];
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: sample outputs at the falling edge, then drive the next tick.
  task automatic step();
    @(negedge clk);
    if (irq) begin
      if (prev_irq) pulse_err++;
      periods.push_back(ticks);
      ticks = 0;
      exp_tout = ~exp_tout;
      if (tout !== exp_tout) tout_err++;
    end
    prev_irq = irq;
    cmp_wr = 1'b0;
    tick = ($urandom_range(99) < tick_pct);
    if (run && tick) ticks++;
  endtask

  task automatic wr(int d);
    cmp_wr = 1'b1;
    cmp_wdata = W'(d);
  endtask

  task automatic start_run();
    run = 1'b1;
    ticks = tick ? 1 : 0;
    periods.delete();
    exp_tout = idle_level;
    prev_irq = 1'b0;
  endtask

  task automatic stop_run();
    run = 1'b0;
    step();
    step();
    chk(tout == idle_level, "R8", "tout while stopped", int'(tout), int'(idle_level));
    chk(irq == 1'b0, "R8", "irq while stopped", int'(irq), 0);
  endtask

  task automatic wait_periods(int n, int limit);
    int k;
    k = 0;
    while (periods.size() < n && k < limit) begin
      step();
      k++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R1", "irq in reset", int'(irq), 0);
    chk(tout == 1'b0, "R1", "tout in reset", int'(tout), 0);
    rst = 1'b0;

    // R1: buffer starts at FFFFH, so the first period is 65536 ticks.
    tick_pct = 100;
    step();
    start_run();
    wait_periods(1, 70000);
    chk(get(0) == SPAN, "R1", "first period", get(0), SPAN);

    // R8: stopped timer ignores ticks.
    idle_level = 1'b1;
    stop_run();
    periods.delete();
    tick_pct = 50;
    repeat (20) step();
    chk(periods.size() == 0, "R8", "irqs while stopped", periods.size(), 0);

    // R2 and R4: irregular ticks, D = 5.
    wr(5);
    step();
    start_run();
    wait_periods(4, 1000);
    for (int k = 0; k < 4; k++)
      chk(get(k) == normal_period(5), "R2", "gated period", get(k), normal_period(5));

    // R4: random compare values, tick rates and idle levels.
    for (int it = 0; it < 5; it++) begin
      d = 3 + int'($urandom_range(37));
      idle_level = 1'($urandom_range(1));
      tick_pct = 30 + int'($urandom_range(70));
      stop_run();
      wr(d);
      step();
      start_run();
      wait_periods(3, 2000);
      for (int k = 0; k < 3; k++)
        chk(get(k) == normal_period(d), "R4", "random period", get(k), normal_period(d));
    end

    // R5: raise above the current count mid-period.
    tick_pct = 100;
    stop_run();
    wr(50);
    step();
    start_run();
    wait_periods(1, 200);
    periods.delete();
    while (ticks < 10) step();
    wr(20);
    wait_periods(1, 200);
    chk(get(0) == normal_period(20), "R5", "raised period", get(0), normal_period(20));

    // R6: lower below the current count mid-period.
    stop_run();
    wr(50);
    step();
    start_run();
    wait_periods(1, 200);
    periods.delete();
    while (ticks < 31) step();
    wr(10);
    wait_periods(2, 70000);
    chk(get(0) == wrap_period(10), "R6", "wrapped period", get(0), wrap_period(10));
    chk(get(1) == normal_period(10), "R6", "period after wrap", get(1), normal_period(10));

    // R7: a write on the matching edge leaves that match unchanged.
    stop_run();
    wr(8);
    step();
    start_run();
    wait_periods(1, 100);
    periods.delete();
    while (ticks < 9) step();
    wr(3);
    wait_periods(2, 100);
    chk(get(0) == normal_period(8), "R7", "period at write", get(0), normal_period(8));
    chk(get(1) == normal_period(3), "R7", "next period", get(1), normal_period(3));

    // R3: pulse width and pin inversion over all scenarios.
    chk(pulse_err == 0, "R3", "wide irq pulses", pulse_err, 0);
    chk(tout_err == 0, "R3", "tout mismatches", tout_err, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule